// File: doc/BRIEF.md
# Clock Failure Detector with Safe-Clock Switchover

The block takes the clock of an external oscillator and passes it to its output. It watches that clock against a safe clock, which is a fast reference clock divided by a selectable power of two. When the watched clock stops toggling, the block latches a sticky failure flag and raises an interrupt. It then moves its output to the safe clock without glitches. Later, software can ask for a return to the external clock. The request stays pending until the external clock is seen toggling again and the output has switched back. The hardware then drops the request.

After the oscillator is enabled, or re-enabled on wake-up, a start-up timer runs on a slow clock. Until it expires, the output is held low and no monitoring takes place. When it expires, the block reports that the clock is ready.

Monitoring works in reference-clock cycles. It uses one enable pulse per safe-clock period and a two-flop synchronized copy of the watched clock. Each handoff between the two clock sources uses a pair of select flops per source, clocked on that source's falling edge. Each source's select is cross-checked against the other source's enable.

Top module: `clk_fail_switch`

## Requirements
- R1: The safe clock period is 2^`div_sel` reference periods, with `div_sel` from 0 to 15. A value of 0 passes the reference clock itself. While the output is on the safe clock, `clk_out` shows this period.
- R2: After `osc_en` rises, `ready` rises after 2^`startup_sel` cycles of `slow_clk`, plus at most four cycles of synchronizer latency. `clk_out` stays low until then.
- R3: Failure is declared once four safe-clock periods pass without both a rising and a falling edge of `mon_clk`. No failure is declared while `mon_clk` keeps toggling faster than that.
- R4: On failure, `fail_sts` and `irq` go high and `on_safe` goes high. `fail_sts` then stays high until a one-cycle `fail_clr` pulse clears it.
- R5: A failure is declared, and `on_safe` can rise, only while `cfd_en` is high. With `cfd_en` low, a dead `mon_clk` leaves `fail_sts` and `on_safe` low.
- R6: A `swb_req` pulse sets `swb_pend`. While `mon_clk` is still dead, `swb_pend` stays high and the output stays on the safe clock.
- R7: Once `mon_clk` toggles again, a pending switch-back clears `on_safe`. `swb_pend` clears after the external gate is active again. `fail_sts` keeps its value until software clears it.
- R8: The two clock gates are never enabled together. After a switch-back, `clk_out` again carries `mon_clk`.
- R9: No failure is declared while `ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Fast reference clock; the control logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | Slow clock that times the start-up window |
| mon_clk | input | 1 | External oscillator clock under watch |
| osc_en | input | 1 | Oscillator enable; a rising edge starts the start-up window |
| startup_sel | input | 4 | Start-up length exponent (2^N slow cycles) |
| div_sel | input | 4 | Safe-clock divider exponent (2^N) |
| cfd_en | input | 1 | Failure detection enable |
| swb_req | input | 1 | One-cycle pulse requesting return to the external clock |
| fail_clr | input | 1 | One-cycle pulse clearing the failure flag |
| clk_out | output | 1 | Gated output clock |
| ready | output | 1 | Start-up window has expired |
| fail_sts | output | 1 | Sticky failure flag |
| on_safe | output | 1 | Output is selected to the safe clock |
| swb_pend | output | 1 | Switch-back request still pending |
| irq | output | 1 | Failure interrupt |

## Verification
The bench uses the default parameter widths. It sweeps `div_sel` over 0 to 4, so the fastest safe clocks and the 16x divider are both reached. Over these settings it checks the failure latency window and the output period after failover. It runs the live-clock scenarios only for dividers of 2 and up, where four safe periods safely cover one 20 ns `mon_clk` period. It also sweeps `startup_sel` over 0 to 4, with one longer window of 32 slow cycles against a dead oscillator. Together these reach the ready latency, the output mask, and the rule that no failure is declared before ready.

// File: rtl/clk_fail_switch.sv
module clk_fail_switch #(
  parameter int DIV_W        = 4,
  parameter int SU_W         = 4,
  parameter int MISS_PERIODS = 4
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             slow_clk,
  input  logic             mon_clk,
  input  logic             osc_en,
  input  logic [SU_W-1:0]  startup_sel,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             cfd_en,
  input  logic             swb_req,
  input  logic             fail_clr,
  output logic             clk_out,
  output logic             ready,
  output logic             fail_sts,
  output logic             on_safe,
  output logic             swb_pend,
  output logic             irq
);
  localparam int DCNT_W = (1 << DIV_W) - 1;
  localparam int SUC_W  = 1 << SU_W;
  localparam int PC_W   = $clog2(MISS_PERIODS);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(MISS_PERIODS - 1);

  // safe clock: tap of a free-running divider, tap 0 is the reference itself
  logic [DCNT_W-1:0] dcnt;
  logic [DCNT_W:0]   taps;
  logic [DCNT_W-1:0] dmask;
  logic              safe_clk, tick;
  assign taps     = {dcnt, ref_clk};
  assign safe_clk = taps[div_sel];
  assign dmask    = {DCNT_W{1'b1}} >> (DCNT_W - int'(div_sel));
  assign tick     = (dcnt & dmask) == '0;

  // start-up window in the slow domain
  logic [1:0]       en_s;
  logic [SUC_W-1:0] su_cnt, su_lim;
  logic [SUC_W:0]   su_pow;
  logic             rdy_slow;
  assign su_pow = (SUC_W+1)'(1) << startup_sel;
  assign su_lim = su_pow[SUC_W-1:0] - SUC_W'(1);

  always_ff @(posedge slow_clk or negedge rst_n)
    if (!rst_n) begin
      en_s <= '0; su_cnt <= '0; rdy_slow <= 1'b0;
    end else begin
      en_s <= {en_s[0], osc_en};
      if (!en_s[1]) begin
        su_cnt <= '0; rdy_slow <= 1'b0;
      end else if (!rdy_slow) begin
        if (su_cnt == su_lim) rdy_slow <= 1'b1;
        su_cnt <= su_cnt + SUC_W'(1);
      end
    end

  // edge-pair monitor and control in the reference domain
  logic [1:0]      rdy_s, msync, eon;
  logic            mon_p, rs_seen, fl_seen, rise, fall, pair, fail_evt;
  logic [PC_W-1:0] pcnt;
  logic            ext_en, safe_en;
  assign ready    = rdy_s[1];
  assign rise     = msync[1] & ~mon_p;
  assign fall     = ~msync[1] & mon_p;
  assign pair     = (rs_seen | rise) & (fl_seen | fall);
  assign fail_evt = ready & cfd_en & ~on_safe & ~pair & tick & (pcnt == PC_LAST);
  assign irq      = fail_sts;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      dcnt <= '0; rdy_s <= '0; msync <= '0; eon <= '0; mon_p <= 1'b0;
      rs_seen <= 1'b0; fl_seen <= 1'b0; pcnt <= '0;
      fail_sts <= 1'b0; on_safe <= 1'b0; swb_pend <= 1'b0;
    end else begin
      dcnt  <= dcnt + DCNT_W'(1);
      rdy_s <= {rdy_s[0], rdy_slow};
      msync <= {msync[0], mon_clk};
      mon_p <= msync[1];
      eon   <= {eon[0], ext_en};
      if (!ready || pair) begin
        rs_seen <= 1'b0; fl_seen <= 1'b0; pcnt <= '0;
      end else begin
        rs_seen <= rs_seen | rise;
        fl_seen <= fl_seen | fall;
        if (tick && pcnt != PC_LAST) pcnt <= pcnt + PC_W'(1);
      end
      fail_sts <= fail_evt | (fail_sts & ~fail_clr);
      if (fail_evt) on_safe <= 1'b1;
      else if (swb_pend && pair) on_safe <= 1'b0;
      if (swb_req) swb_pend <= 1'b1;
      else if (swb_pend && !on_safe && eon[1]) swb_pend <= 1'b0;
    end

  // glitch-free handoff; a failed source is dropped asynchronously
  logic ext_q1, safe_q1, ext_rst_n;
  assign ext_rst_n = rst_n & ~on_safe;

  always_ff @(negedge mon_clk or negedge ext_rst_n)
    if (!ext_rst_n) begin
      ext_q1 <= 1'b0; ext_en <= 1'b0;
    end else begin
      ext_q1 <= ready & ~safe_en;
      ext_en <= ext_q1;
    end

  always_ff @(negedge safe_clk or negedge rst_n)
    if (!rst_n) begin
      safe_q1 <= 1'b0; safe_en <= 1'b0;
    end else begin
      safe_q1 <= on_safe & ~ext_en;
      safe_en <= safe_q1;
    end

  assign clk_out = (mon_clk & ext_en) | (safe_clk & safe_en);
endmodule

// File: rtl/clk_fail_switch_chk.sv
module clk_fail_switch_chk (
  input logic ref_clk,
  input logic rst_n,
  input logic ready,
  input logic fail_sts,
  input logic on_safe,
  input logic swb_pend,
  input logic fail_clr,
  input logic cfd_en,
  input logic ext_en,
  input logic safe_en
);
  AST_FAIL_STICKY: assert property (@(posedge ref_clk) disable iff (!rst_n)
    fail_sts && !fail_clr |=> fail_sts); // R4
  AST_SAFE_WITH_FAIL: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(on_safe) |-> fail_sts); // R4
  AST_SAFE_NEEDS_CFD: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(on_safe) |-> $past(cfd_en)); // R5
  AST_NO_FAIL_UNREADY: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !ready && !fail_sts |=> !fail_sts); // R9
  AST_ONE_GATE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(ext_en && safe_en)); // R8
  AST_SWB_DONE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(swb_pend) |-> !on_safe); // R7
endmodule

bind clk_fail_switch clk_fail_switch_chk u_chk (
  .ref_clk(ref_clk), .rst_n(rst_n), .ready(ready), .fail_sts(fail_sts),
  .on_safe(on_safe), .swb_pend(swb_pend), .fail_clr(fail_clr),
  .cfd_en(cfd_en), .ext_en(ext_en), .safe_en(safe_en));

// File: tb/clk_fail_switch_tb.sv
module clk_fail_switch_tb;
  logic ref_clk = 1'b0, slow_clk = 1'b0, mon_clk = 1'b0, mon_run = 1'b0;
  logic rst_n = 1'b0, osc_en = 1'b0, cfd_en = 1'b0, swb_req = 1'b0, fail_clr = 1'b0;
  logic [3:0] startup_sel = '0, div_sel = '0;
  logic clk_out, ready, fail_sts, on_safe, swb_pend, irq;
  int vectors = 0, errors = 0, cycles = 0, out_edges = 0, slow_cnt = 0;

  always #4 ref_clk = ~ref_clk;
  always #20 slow_clk = ~slow_clk;
  always begin #10; if (mon_run) mon_clk = ~mon_clk; else mon_clk = 1'b0; end
  always @(posedge clk_out) out_edges++;
  always @(posedge slow_clk) slow_cnt++;

  clk_fail_switch u_dut (
    .ref_clk(ref_clk), .rst_n(rst_n), .slow_clk(slow_clk), .mon_clk(mon_clk),
    .osc_en(osc_en), .startup_sel(startup_sel), .div_sel(div_sel), .cfd_en(cfd_en),
    .swb_req(swb_req), .fail_clr(fail_clr), .clk_out(clk_out), .ready(ready),
    .fail_sts(fail_sts), .on_safe(on_safe), .swb_pend(swb_pend), .irq(irq));

  always @(posedge ref_clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge ref_clk);
  endtask

  task automatic do_reset();
    @(negedge ref_clk);
    rst_n = 1'b0; osc_en = 1'b0; cfd_en = 1'b0; swb_req = 1'b0; fail_clr = 1'b0;
    mon_run = 1'b0;
    cyc(4);
    rst_n = 1'b1;
    cyc(2);
  endtask

  task automatic wait_ready(input int limit);
    for (int i = 0; i < limit && !ready; i++) @(negedge ref_clk);
  endtask

  task automatic pulse_swb();
    swb_req = 1'b1; @(negedge ref_clk); swb_req = 1'b0;
  endtask

  task automatic pulse_clr();
    fail_clr = 1'b1; @(negedge ref_clk); fail_clr = 1'b0;
  endtask

  initial begin
    do_reset();
    chk(!clk_out && !ready && !fail_sts && !on_safe && !irq && !swb_pend,
        "R4 reset state", {clk_out, ready, fail_sts, on_safe, irq, swb_pend}, 0);

    // R2: start-up window sweep with a live oscillator
    for (int n = 0; n <= 4; n++) begin
      do_reset();
      startup_sel = 4'(n); mon_run = 1'b1; cfd_en = 1'b1;
      out_edges = 0; slow_cnt = 0; osc_en = 1'b1;
      wait_ready(2000);
      chk(slow_cnt >= (1 << n) + 1 && slow_cnt <= (1 << n) + 4, "R2 ready latency",
          slow_cnt, (1 << n) + 2);
      chk(out_edges == 0, "R2 output masked before ready", out_edges, 0);
      cyc(20); out_edges = 0; cyc(80);
      chk(out_edges >= 31 && out_edges <= 33, "R8 output follows oscillator", out_edges, 32);
    end

    // R9: long window against a dead oscillator
    do_reset();
    startup_sel = 4'd5; cfd_en = 1'b1; osc_en = 1'b1;
    wait_ready(2000);
    chk(ready && !fail_sts, "R9 no failure before ready", fail_sts, 0);
    cyc(100);
    chk(fail_sts, "R3 dead clock fails after ready", fail_sts, 1);

    // divider sweep: failure, failover, switch-back
    for (int n = 0; n <= 4; n++) begin
      int lat, lo;
      do_reset();
      div_sel = 4'(n); startup_sel = 4'd0; mon_run = (n > 0); cfd_en = 1'b1; osc_en = 1'b1;
      wait_ready(200);
      if (n > 0) begin
        cyc(200);
        chk(!fail_sts && !on_safe, "R3 live clock never fails", fail_sts, 0);
      end
      mon_run = 1'b0;
      lat = 0;
      while (!fail_sts && lat < 400) begin @(negedge ref_clk); lat++; end
      lo = 3 * (1 << n) - 4; if (lo < 0) lo = 0;
      chk(lat >= lo && lat <= 4 * (1 << n) + 8, "R3 failure latency", lat, 4 * (1 << n));
      chk(fail_sts && irq && on_safe, "R4 failure raises status and irq",
          {fail_sts, irq, on_safe}, 7);
      cyc(40); out_edges = 0; cyc(64);
      chk(out_edges >= (64 >> n) - 1 && out_edges <= (64 >> n) + 1, "R1 safe clock period",
          out_edges, 64 >> n);
      pulse_swb();
      cyc(100);
      chk(on_safe && swb_pend, "R6 switch-back pends on dead clock", {on_safe, swb_pend}, 3);
      out_edges = 0; cyc(64);
      chk(out_edges >= (64 >> n) - 1 && out_edges <= (64 >> n) + 1, "R6 output stays safe",
          out_edges, 64 >> n);
      if (n > 0) begin
        mon_run = 1'b1;
        cyc(100);
        chk(!on_safe && !swb_pend, "R7 switch-back completes", {on_safe, swb_pend}, 0);
        chk(fail_sts, "R7 failure history retained", fail_sts, 1);
        out_edges = 0; cyc(80);
        chk(out_edges >= 31 && out_edges <= 33, "R8 output back on oscillator", out_edges, 32);
        pulse_clr();
        chk(!fail_sts && !irq, "R4 software clear", {fail_sts, irq}, 0);
        cfd_en = 1'b0; mon_run = 1'b0;
        cyc(300);
        chk(!fail_sts && !on_safe, "R5 disabled detection ignores dead clock",
            {fail_sts, on_safe}, 0);
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule